// File: doc/BRIEF.md
# SPI Receive FIFO with Overflow Control

This block buffers frames received by an SPI shifter until a host or DMA engine collects them. Each completed frame first lands in a one-frame hold stage, which stands for the shift register. From there it moves into a small circular store as soon as the store has room. A reader takes entries through a pop port. The pop port always shows the entry chosen by the pop pointer, and every accepted pop advances that pointer with wrap-around.

The block reports four things: the number of stored entries, the pop pointer, a sticky overflow flag and a drain flag. A mode input decides what happens when a frame arrives while both the store and the hold stage are full. The new frame either replaces the held frame or is thrown away. The drain flag tells the reader that data has arrived. It stays set after the store empties, and it clears on a write-one-to-clear strobe or on a DMA read-complete pulse taken while the store is empty.

Frame input rules: `frm_valid` has no ready, because an SPI link cannot be stalled, so back-pressure shows up as an overflow instead. Pop port rules: `rd_valid` is high while the entry count is non-zero. A pop is taken on a clock edge where both `rd_valid` and `rd_ready` are high, and `rd_data` is valid during that cycle. Raising `rd_ready` while `rd_valid` is low has no effect.

Top module: `spi_rx_fifo`

## Requirements
- R1: A synchronous active-high reset clears the entry count, the write and pop pointers, the hold stage and both flags, so `rd_valid` is 0.
- R2: A frame with `frm_valid` high is captured into the hold stage at that edge. On the next edge where the count is below DEPTH, the held frame moves into the store and the count rises by one. The count never exceeds DEPTH.
- R3: `rd_data` shows the store entry at `pop_ptr`. Entries come out in arrival order. Each accepted pop advances `pop_ptr` by one and lowers the count by one.
- R4: `pop_ptr` counts from 0 up to DEPTH-1, and after DEPTH-1 the next pop returns it to 0.
- R5: A pop requested while the count is 0 is ignored: the count and `pop_ptr` keep their values.
- R6: A frame arriving while the count equals DEPTH and the hold stage is full is an overflow event, and `ovf_flag` reads 1 after that edge.
- R7: On an overflow event with `ovr_keep`=1, the new frame replaces the held frame. With `ovr_keep`=0, the new frame is discarded and the held frame is kept.
- R8: `ovf_flag` is sticky. Only `ovf_clr`=1 clears it, and a new overflow event in the same cycle as `ovf_clr` wins, leaving the flag at 1.
- R9: `drain_flag` reads 1 in the cycle after any cycle in which the count is non-zero.
- R10: With the count at 0, `drain_flag` holds its value until `drain_clr`=1 or `dma_done`=1, which clear it at the next edge. While the count is non-zero, neither input clears it.
- R11: A transfer from the hold stage and an accepted pop on the same edge leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Completed frame strobe from the shifter |
| frm_data | input | W | Completed frame contents |
| ovr_keep | input | 1 | Overflow mode: 1 replaces the held frame, 0 discards the new frame |
| rd_valid | output | 1 | Store holds at least one entry |
| rd_ready | input | 1 | Pop request (read of the pop register) |
| rd_data | output | W | Entry at the pop pointer |
| pop_ptr | output | PW | Pop pointer, an offset in entries from entry 0 |
| entry_count | output | CW | Number of stored entries |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| drain_flag | output | 1 | Drain flag |
| drain_clr | input | 1 | Write-one-to-clear for the drain flag |
| dma_done | input | 1 | DMA pop-read completion pulse |

## Verification
Two functions can fall on the same edge: a transfer from the hold stage into the store, and an accepted pop. The bench provokes this by preloading two entries and then driving a frame every cycle while popping every cycle. It judges the result by requiring the count to hold steady through the stream, and by having the scoreboard confirm afterwards that every frame comes out in order. Overflow clear and overflow set are also driven on the same edge, and the flag must stay set.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [1:0] {
    HOLD_IDLE,
    HOLD_LOAD,
    HOLD_OVWR,
    HOLD_DROP
  } hold_act_e;
endpackage

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frm_valid,
  input  logic [W-1:0] frm_data,
  input  logic         ovr_keep,
  input  logic         store_full,
  output logic         hold_full,
  output logic [W-1:0] hold_data,
  output logic         xfer,
  output logic         ovf_evt
);
  import spi_rx_pkg::*;

  hold_act_e act;

  assign xfer    = hold_full && !store_full;
  assign ovf_evt = frm_valid && hold_full && store_full;

  always_comb begin
    if (frm_valid && (!hold_full || xfer)) act = HOLD_LOAD;
    else if (ovf_evt && ovr_keep)          act = HOLD_OVWR;
    else if (ovf_evt)                      act = HOLD_DROP;
    else                                   act = HOLD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      case (act)
        HOLD_LOAD, HOLD_OVWR: begin
          hold_full <= 1'b1;
          hold_data <= frm_data;
        end
        default: if (xfer) hold_full <= 1'b0;
      endcase
    end
  end

  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !ovr_keep) |=> (hold_full && $stable(hold_data)));
  p_keep_replaces_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && ovr_keep) |=> (hold_full && hold_data == $past(frm_data)));
endmodule

// File: rtl/rx_store.sv
module rx_store #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic [W-1:0]  rd_data,
  output logic [PW-1:0] pop_ptr,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic          pop;

  assign full    = (count == CW'(DEPTH));
  assign pop     = pop_req && (count != '0);
  assign rd_data = mem[pop_ptr];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      pop_ptr <= '0;
      count   <= '0;
    end else begin
      if (push) wr_ptr  <= ptr_next(wr_ptr);
      if (pop)  pop_ptr <= ptr_next(pop_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && count == '0 && !push) |=> ($stable(count) && $stable(pop_ptr)));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && pop_ptr == PW'(DEPTH - 1)) |=> (pop_ptr == '0));
  p_pushpop_r11: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          ovf_evt,
  input  logic          ovf_clr,
  input  logic          drain_clr,
  input  logic          dma_done,
  output logic          ovf_flag,
  output logic          drain_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      drain_flag <= 1'b0;
    end else begin
      if (ovf_evt)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;

      if (count != '0)                drain_flag <= 1'b1;
      else if (drain_clr || dma_done) drain_flag <= 1'b0;
    end
  end

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  p_drain_set_r9: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> drain_flag);
  p_drain_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (drain_flag && !drain_clr && !dma_done) |=> drain_flag);
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_valid,
  input  logic [W-1:0]  frm_data,
  input  logic          ovr_keep,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  output logic [PW-1:0] pop_ptr,
  output logic [CW-1:0] entry_count,
  output logic          ovf_flag,
  input  logic          ovf_clr,
  output logic          drain_flag,
  input  logic          drain_clr,
  input  logic          dma_done
);
  logic         hold_full;
  logic [W-1:0] hold_data;
  logic         xfer;
  logic         ovf_evt;
  logic         store_full;

  rx_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .ovr_keep(ovr_keep), .store_full(store_full), .hold_full(hold_full),
    .hold_data(hold_data), .xfer(xfer), .ovf_evt(ovf_evt)
  );

  rx_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(xfer), .push_data(hold_data),
    .pop_req(rd_ready), .rd_data(rd_data), .pop_ptr(pop_ptr),
    .count(entry_count), .full(store_full)
  );

  rx_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .count(entry_count), .ovf_evt(ovf_evt),
    .ovf_clr(ovf_clr), .drain_clr(drain_clr), .dma_done(dma_done),
    .ovf_flag(ovf_flag), .drain_flag(drain_flag)
  );

  assign rd_valid = (entry_count != '0);

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && hold_full && entry_count == CW'(DEPTH)) |=> ovf_flag);
  p_xfer_counts_r2: assert property (@(posedge clk) disable iff (rst)
    (hold_full && entry_count < CW'(DEPTH) && !(rd_ready && rd_valid))
      |=> (entry_count == $past(entry_count) + 1'b1));
endmodule

// File: tb/tb_spi_rx_fifo.sv
`timescale 1ns/1ps
module tb_spi_rx_fifo;
  localparam int W = 32;
  localparam int DEPTH = 4;
  localparam int PW = 2;
  localparam int CW = 3;

  logic clk = 0, rst = 1;
  logic frm_valid = 0, ovr_keep = 0, rd_ready = 0;
  logic ovf_clr = 0, drain_clr = 0, dma_done = 0;
  logic [W-1:0] frm_data = '0;
  logic rd_valid, ovf_flag, drain_flag;
  logic [W-1:0] rd_data;
  logic [PW-1:0] pop_ptr;
  logic [CW-1:0] entry_count;

  int checks = 0, failures = 0, pops = 0;
  logic [W-1:0] q[$];

  always #2 clk = ~clk;

  spi_rx_fifo #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .ovr_keep(ovr_keep), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .pop_ptr(pop_ptr), .entry_count(entry_count),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .drain_flag(drain_flag),
    .drain_clr(drain_clr), .dma_done(dma_done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [W-1:0] d, input bit replace_last);
    if (replace_last) void'(q.pop_back());
    q.push_back(d);
    frm_valid = 1; frm_data = d;
    tick();
    frm_valid = 0;
  endtask

  task automatic drain_all();
    rd_ready = 1;
    for (int k = 0; k < 20 && entry_count != 0; k++) tick();
    rd_ready = 0;
    check(q.size() == 0, "R3 scoreboard empty after drain", q.size(), 0);
    check(pop_ptr == PW'(pops % DEPTH), "R4 pop_ptr wrap", pop_ptr, pops % DEPTH);
  endtask

  // monitor: compare every accepted pop against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid && rd_ready) begin
      if (q.size() == 0) check(0, "R3 pop with empty scoreboard", rd_data, 0);
      else begin
        logic [W-1:0] e;
        e = q.pop_front();
        check(rd_data == e, "R3 pop data order", rd_data, e);
      end
      pops++;
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    // R1 reset state
    check(entry_count == 0 && !rd_valid, "R1 count after reset", entry_count, 0);
    check(!ovf_flag && !drain_flag && pop_ptr == 0, "R1 flags and ptr after reset",
          {ovf_flag, drain_flag, pop_ptr}, 0);

    // R5 pop on empty ignored
    rd_ready = 1; tick(); rd_ready = 0;
    check(entry_count == 0 && pop_ptr == 0, "R5 empty pop ignored", {entry_count, pop_ptr}, 0);

    // R2 single frame: hold at edge 1, store at edge 2
    send(32'hA001, 0);
    check(entry_count == 0, "R2 frame still in hold", entry_count, 0);
    tick();
    check(entry_count == 1 && rd_valid, "R2 frame in store", entry_count, 1);
    tick();
    check(drain_flag == 1, "R9 drain flag set", drain_flag, 1);
    dma_done = 1; tick(); dma_done = 0;
    check(drain_flag == 1, "R10 dma_done ignored while non-empty", drain_flag, 1);
    drain_all();
    tick(); tick();
    check(drain_flag == 1, "R10 drain flag holds when empty", drain_flag, 1);
    dma_done = 1; tick(); dma_done = 0;
    check(drain_flag == 0, "R10 dma_done clears when empty", drain_flag, 0);

    // R6/R7 overflow, discard mode
    ovr_keep = 0;
    for (int i = 0; i < 5; i++) send(32'hB000 + i, 0);
    check(entry_count == 4 && !ovf_flag, "R6 full without overflow", {entry_count, ovf_flag}, 8);
    frm_valid = 1; frm_data = 32'hBDEAD; tick(); frm_valid = 0;
    check(ovf_flag == 1, "R6 overflow flag set", ovf_flag, 1);
    check(entry_count == 4, "R2 count bounded", entry_count, 4);
    tick(); tick();
    check(ovf_flag == 1, "R8 overflow sticky", ovf_flag, 1);
    ovf_clr = 1; tick(); ovf_clr = 0;
    check(ovf_flag == 0, "R8 overflow cleared by w1c", ovf_flag, 0);
    drain_all(); // R7 discard: B0..B4 only
    drain_clr = 1; tick(); drain_clr = 0;
    check(drain_flag == 0, "R10 w1c clears drain flag", drain_flag, 0);

    // R7 replace mode, R8 set wins over clear
    ovr_keep = 1;
    for (int i = 0; i < 5; i++) send(32'hC000 + i, 0);
    ovf_clr = 1;
    send(32'hC0FF, 1);
    ovf_clr = 0;
    check(ovf_flag == 1, "R8 set wins over clear", ovf_flag, 1);
    tick();
    drain_all(); // R7 replace: C0..C3 then C0FF
    ovf_clr = 1; tick(); ovf_clr = 0;

    // R11 push and pop on the same edge
    send(32'hD000, 0); send(32'hD001, 0); tick();
    check(entry_count == 2, "R11 preload", entry_count, 2);
    rd_ready = 1;
    for (int i = 0; i < 6; i++) begin
      send(32'hD100 + i, 0);
      check(entry_count == 1, "R11 count steady under push+pop", entry_count, 1);
    end
    rd_ready = 0;
    tick();
    check(entry_count == 2, "R11 last held frame lands", entry_count, 2);
    drain_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule